// File: doc/BRIEF.md
# Transactional Cache with Overflow Spill

This block is a small set-associative write-back data cache for hardware transactions. While a transaction is open, every line the core touches is marked as speculative. When such a line has to leave the cache to make room, it is not lost. Its full address, data and dirty flag move into an overflow table, and the set it came from is flagged. A later miss in a flagged set looks in the table before it asks memory. So a transaction can touch more lines than the cache holds and still stay intact.

The core starts a transaction with `tx_begin`. It ends it with `tx_commit`. Commit is a multi-cycle walk. It first clears the speculative mark on every line, then writes every dirty table entry to its home address. During that walk `busy` is high and core requests wait. Three things abort the transaction: a snooped access that hits a speculative line (cached or spilled), an interrupt or thread-switch indication, or a spill that finds the table full. On abort, speculatively written lines are dropped, every mark and set flag is cleared, and the table is emptied. The core holds `core_req` with its fields until `core_ack` pulses.

Top module: `txc_ovf_ctrl`

## Requirements
- R1: While reset is low, `busy`, `tx_active`, `core_ack` and `mem_req` are low, and all lines and table entries start invalid.
- R2: Outside a transaction, accesses are plain write-back and set no speculative mark or set flag. A write stays in the cache, and memory is written only when that dirty line is evicted.
- R3: A transactional access that hits a dirty line not yet marked first writes the line's data to its home address, and only then is acknowledged.
- R4: When a speculative line is evicted, its address, data and dirty flag move into the overflow table. No memory write happens for it.
- R5: A miss in a flagged set whose address is in the overflow table returns the table's data and issues no memory read.
- R6: Commit keeps `busy` high for at least one cycle per cache line plus one per table entry. It writes every dirty table entry to its home address, pulses `tx_committed` once and leaves `tx_active` low. Committed data stays readable.
- R7: A valid snoop whose address matches a speculative line, either in the cache or in the table, aborts the transaction. `tx_aborted` pulses, `tx_active` drops, and later reads return the values from before the transaction.
- R8: A snoop to an address the transaction has not touched has no effect, and the transaction can still commit.
- R9: `tx_intr` during a transaction aborts it with the same clean-up as R7.
- R10: A spill that finds all table entries in use aborts the transaction. The pending access is then served non-transactionally.
- R11: A snoop conflict that arrives while the commit walk is running, or in the same cycle as the commit request, is ignored, and the commit completes.
- R12: `core_ack` is never high while `busy` is high.
- R13: `mem_req` stays high, with a stable address, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access request, held until acknowledged |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address; the low IDX_W bits select the set |
| core_wdata | input | DATA_W | Write data |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read data, valid with core_ack |
| busy | output | 1 | Controller is in a multi-cycle sequence; requests wait |
| tx_begin | input | 1 | Open a transaction (taken when idle) |
| tx_commit | input | 1 | Commit the open transaction |
| tx_intr | input | 1 | Interrupt or thread switch; aborts an open transaction |
| tx_active | output | 1 | A transaction is open |
| tx_committed | output | 1 | One-cycle pulse at the end of commit |
| tx_aborted | output | 1 | One-cycle pulse when a transaction is aborted |
| snoop_valid | input | 1 | Another agent accesses snoop_addr |
| snoop_addr | input | ADDR_W | Snooped word address |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The embedded properties check the following on every cycle: that `core_ack` and `busy` are never high together, and that commit and abort pulses never coincide. They also check that no abort can happen inside the commit walk, and that set flags exist only while a transaction is open. Finally, they check that memory requests stay steady until acknowledged and that table write-back during commit uses writes. Other behaviours need whole scenarios in the bench, because they are only visible through values read back later and the bench's own memory image. These are: data moving into the table and being found there without a memory read, the clean-before-touch write, commit writing spilled data home, and restore after a conflict, an interrupt or a full table.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_MEM_RD    = 3'd1,
        S_MEM_WR    = 3'd2,
        S_CMT_LINES = 3'd3,
        S_CMT_TABLE = 3'd4,
        S_CMT_WR    = 3'd5
    } fsm_e;

endpackage

// File: rtl/txc_way_match.sv
module txc_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 6,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]            vld_i,
    input  logic [WAYS-1:0]            tm_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]           key_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o,
    output logic                       tx_hit_o
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = vld_i[w] && (tag_i[w] == key_i);
    end

    always_comb begin
        hit_o    = |eq;
        tx_hit_o = |(eq & tm_i);
        way_o    = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/txc_ovf_cam.sv
module txc_ovf_cam #(
    parameter int N      = 16,
    parameter int ADDR_W = 8,
    parameter int IW     = 4
) (
    input  logic [N-1:0]             vld_i,
    input  logic [N-1:0][ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0]        key_i,
    output logic                     match_o,
    output logic [IW-1:0]            match_idx_o,
    output logic                     free_o,
    output logic [IW-1:0]            free_idx_o
);
    logic [N-1:0] eq;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = vld_i[i] && (addr_i[i] == key_i);
    end

    always_comb begin
        match_o     = |eq;
        free_o      = ~&vld_i;
        match_idx_o = '0;
        free_idx_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i])     match_idx_o = IW'(i);
            if (!vld_i[i]) free_idx_o  = IW'(i);
        end
    end
endmodule

// File: rtl/txc_ovf_ctrl.sv
module txc_ovf_ctrl
    import txc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int OVF_N  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ack,
    output logic [DATA_W-1:0] core_rdata,
    output logic              busy,
    input  logic              tx_begin,
    input  logic              tx_commit,
    input  logic              tx_intr,
    output logic              tx_active,
    output logic              tx_committed,
    output logic              tx_aborted,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int LINES  = SETS * WAYS;
    localparam int LIDX_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int OVF_IW = (OVF_N > 1) ? $clog2(OVF_N) : 1;
    localparam int CNT_W  = (LIDX_W > OVF_IW) ? LIDX_W : OVF_IW;

    typedef struct packed {
        logic              vld;
        logic              dty;
        logic              tm;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic              vld;
        logic              dty;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ovf_t;

    typedef struct packed {
        fsm_e                       st;
        line_t [LINES-1:0]          ln;
        ovf_t  [OVF_N-1:0]          tb;
        logic  [SETS-1:0]           ofl;
        logic  [SETS-1:0][WAY_W-1:0] vp;
        logic                       act;
        logic                       abt_pend;
        logic                       ack;
        logic                       cmt_p;
        logic                       abt_p;
        logic  [DATA_W-1:0]         rdata;
        logic  [CNT_W-1:0]          cnt;
        logic                       mreq;
        logic                       mwe;
        logic  [ADDR_W-1:0]         maddr;
        logic  [DATA_W-1:0]         mwdata;
        logic  [WAY_W-1:0]          pway;
    } state_t;

    state_t cur_q, nxt_d;

    function automatic logic [LIDX_W-1:0] lix(input logic [IDX_W-1:0] s, input logic [WAY_W-1:0] w);
        return LIDX_W'(s) * LIDX_W'(WAYS) + LIDX_W'(w);
    endfunction

    // per-set views for the core and snoop lookups, table views for the CAMs
    logic [IDX_W-1:0] c_set, s_set, m_set;
    logic [TAG_W-1:0] c_tag, s_tag;
    logic [WAYS-1:0]  c_vld, c_tm, s_vld, s_tm;
    logic [WAYS-1:0][TAG_W-1:0] c_tags, s_tags;
    logic [OVF_N-1:0] t_vld;
    logic [OVF_N-1:0][ADDR_W-1:0] t_addr;

    assign c_set = core_addr[IDX_W-1:0];
    assign c_tag = core_addr[ADDR_W-1:IDX_W];
    assign s_set = snoop_addr[IDX_W-1:0];
    assign s_tag = snoop_addr[ADDR_W-1:IDX_W];
    assign m_set = cur_q.maddr[IDX_W-1:0];

    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign c_vld[w]  = cur_q.ln[lix(c_set, WAY_W'(w))].vld;
        assign c_tm[w]   = cur_q.ln[lix(c_set, WAY_W'(w))].tm;
        assign c_tags[w] = cur_q.ln[lix(c_set, WAY_W'(w))].tag;
        assign s_vld[w]  = cur_q.ln[lix(s_set, WAY_W'(w))].vld;
        assign s_tm[w]   = cur_q.ln[lix(s_set, WAY_W'(w))].tm;
        assign s_tags[w] = cur_q.ln[lix(s_set, WAY_W'(w))].tag;
    end

    for (genvar i = 0; i < OVF_N; i++) begin : g_tview
        assign t_vld[i]  = cur_q.tb[i].vld;
        assign t_addr[i] = cur_q.tb[i].addr;
    end

    logic c_hit, c_txhit, s_hit, s_txhit;
    logic [WAY_W-1:0] c_way, s_way;
    logic c_tmatch, c_free, s_tmatch, s_free;
    logic [OVF_IW-1:0] c_tidx, c_fidx, s_tidx, s_fidx;

    txc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_core_match (
        .vld_i(c_vld), .tm_i(c_tm), .tag_i(c_tags), .key_i(c_tag),
        .hit_o(c_hit), .way_o(c_way), .tx_hit_o(c_txhit));

    txc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_snoop_match (
        .vld_i(s_vld), .tm_i(s_tm), .tag_i(s_tags), .key_i(s_tag),
        .hit_o(s_hit), .way_o(s_way), .tx_hit_o(s_txhit));

    txc_ovf_cam #(.N(OVF_N), .ADDR_W(ADDR_W), .IW(OVF_IW)) u_core_cam (
        .vld_i(t_vld), .addr_i(t_addr), .key_i(core_addr),
        .match_o(c_tmatch), .match_idx_o(c_tidx), .free_o(c_free), .free_idx_o(c_fidx));

    txc_ovf_cam #(.N(OVF_N), .ADDR_W(ADDR_W), .IW(OVF_IW)) u_snoop_cam (
        .vld_i(t_vld), .addr_i(t_addr), .key_i(snoop_addr),
        .match_o(s_tmatch), .match_idx_o(s_tidx), .free_o(s_free), .free_idx_o(s_fidx));

    logic committing;
    assign committing = cur_q.st inside {S_CMT_LINES, S_CMT_TABLE, S_CMT_WR};

    always_comb begin
        logic [WAY_W-1:0]  vway;
        logic              vfound, do_abort, tbl_adv, cmt_done;
        logic [LIDX_W-1:0] hl, vl;
        nxt_d    = cur_q;
        nxt_d.ack   = 1'b0;
        nxt_d.cmt_p = 1'b0;
        nxt_d.abt_p = 1'b0;
        do_abort = 1'b0;
        tbl_adv  = 1'b0;
        cmt_done = 1'b0;
        hl = lix(c_set, c_way);

        // victim: first invalid way, else round-robin pointer
        vway   = cur_q.vp[c_set];
        vfound = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vfound && !c_vld[w]) begin
                vway   = WAY_W'(w);
                vfound = 1'b1;
            end
        end
        vl = lix(c_set, vway);

        // conflicts and interrupts latch an abort; none counted during commit
        if (cur_q.act && !committing &&
            ((snoop_valid && (s_txhit || s_tmatch)) || tx_intr))
            nxt_d.abt_pend = 1'b1;

        unique case (cur_q.st)
            S_IDLE: begin
                if (cur_q.abt_pend) begin
                    do_abort = 1'b1;
                end else if (tx_commit && cur_q.act) begin
                    nxt_d.st       = S_CMT_LINES;
                    nxt_d.cnt      = '0;
                    nxt_d.abt_pend = 1'b0;
                end else if (tx_begin && !cur_q.act) begin
                    nxt_d.act = 1'b1;
                end else if (core_req) begin
                    if (c_hit) begin
                        if (cur_q.act && cur_q.ln[hl].dty && !cur_q.ln[hl].tm) begin
                            nxt_d.st     = S_MEM_WR;       // clean before speculative touch
                            nxt_d.mreq   = 1'b1;
                            nxt_d.mwe    = 1'b1;
                            nxt_d.maddr  = core_addr;
                            nxt_d.mwdata = cur_q.ln[hl].data;
                            nxt_d.pway   = c_way;
                        end else begin
                            nxt_d.ack = 1'b1;
                            if (core_we) begin
                                nxt_d.ln[hl].data = core_wdata;
                                nxt_d.ln[hl].dty  = 1'b1;
                            end else begin
                                nxt_d.rdata = cur_q.ln[hl].data;
                            end
                            if (cur_q.act) nxt_d.ln[hl].tm = 1'b1;
                            nxt_d.vp[c_set] = WAY_W'((int'(c_way) + 1) % WAYS);
                        end
                    end else if (cur_q.ln[vl].vld && cur_q.ln[vl].tm) begin
                        if (c_free) begin
                            nxt_d.tb[c_fidx].vld  = 1'b1;
                            nxt_d.tb[c_fidx].dty  = cur_q.ln[vl].dty;
                            nxt_d.tb[c_fidx].addr = {cur_q.ln[vl].tag, c_set};
                            nxt_d.tb[c_fidx].data = cur_q.ln[vl].data;
                            nxt_d.ln[vl]          = '0;
                            nxt_d.ofl[c_set]      = 1'b1;
                        end else begin
                            do_abort = 1'b1;
                        end
                    end else if (cur_q.ln[vl].vld && cur_q.ln[vl].dty) begin
                        nxt_d.st     = S_MEM_WR;
                        nxt_d.mreq   = 1'b1;
                        nxt_d.mwe    = 1'b1;
                        nxt_d.maddr  = {cur_q.ln[vl].tag, c_set};
                        nxt_d.mwdata = cur_q.ln[vl].data;
                        nxt_d.pway   = vway;
                    end else if (cur_q.ofl[c_set] && c_tmatch) begin
                        nxt_d.ln[vl].vld  = 1'b1;
                        nxt_d.ln[vl].tm   = 1'b1;
                        nxt_d.ln[vl].dty  = cur_q.tb[c_tidx].dty;
                        nxt_d.ln[vl].tag  = c_tag;
                        nxt_d.ln[vl].data = cur_q.tb[c_tidx].data;
                        nxt_d.tb[c_tidx].vld = 1'b0;
                    end else begin
                        nxt_d.st    = S_MEM_RD;
                        nxt_d.mreq  = 1'b1;
                        nxt_d.mwe   = 1'b0;
                        nxt_d.maddr = core_addr;
                        nxt_d.pway  = vway;
                    end
                end
            end
            S_MEM_RD: if (mem_ack) begin
                nxt_d.mreq = 1'b0;
                nxt_d.st   = S_IDLE;
                nxt_d.ln[lix(m_set, cur_q.pway)] =
                    '{vld: 1'b1, dty: 1'b0, tm: 1'b0,
                      tag: cur_q.maddr[ADDR_W-1:IDX_W], data: mem_rdata};
            end
            S_MEM_WR: if (mem_ack) begin
                nxt_d.mreq = 1'b0;
                nxt_d.st   = S_IDLE;
                nxt_d.ln[lix(m_set, cur_q.pway)].dty = 1'b0;
            end
            S_CMT_LINES: begin
                nxt_d.ln[cur_q.cnt[LIDX_W-1:0]].tm = 1'b0;
                if (cur_q.cnt == CNT_W'(LINES - 1)) begin
                    nxt_d.st  = S_CMT_TABLE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            S_CMT_TABLE: begin
                if (cur_q.tb[cur_q.cnt[OVF_IW-1:0]].vld && cur_q.tb[cur_q.cnt[OVF_IW-1:0]].dty) begin
                    nxt_d.st     = S_CMT_WR;
                    nxt_d.mreq   = 1'b1;
                    nxt_d.mwe    = 1'b1;
                    nxt_d.maddr  = cur_q.tb[cur_q.cnt[OVF_IW-1:0]].addr;
                    nxt_d.mwdata = cur_q.tb[cur_q.cnt[OVF_IW-1:0]].data;
                end else begin
                    nxt_d.tb[cur_q.cnt[OVF_IW-1:0]].vld = 1'b0;
                    tbl_adv = 1'b1;
                end
            end
            S_CMT_WR: if (mem_ack) begin
                nxt_d.mreq = 1'b0;
                nxt_d.tb[cur_q.cnt[OVF_IW-1:0]].vld = 1'b0;
                tbl_adv = 1'b1;
            end
            default: nxt_d.st = S_IDLE;
        endcase

        if (tbl_adv) begin
            if (cur_q.cnt == CNT_W'(OVF_N - 1)) cmt_done = 1'b1;
            else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
                nxt_d.st  = S_CMT_TABLE;
            end
        end

        if (cmt_done) begin
            nxt_d.st       = S_IDLE;
            nxt_d.act      = 1'b0;
            nxt_d.ofl      = '0;
            nxt_d.cmt_p    = 1'b1;
            nxt_d.abt_pend = 1'b0;
        end

        if (do_abort) begin
            for (int i = 0; i < LINES; i++) begin
                if (cur_q.ln[i].tm && cur_q.ln[i].dty) begin
                    nxt_d.ln[i].vld = 1'b0;
                    nxt_d.ln[i].dty = 1'b0;
                end
                nxt_d.ln[i].tm = 1'b0;
            end
            for (int i = 0; i < OVF_N; i++) nxt_d.tb[i].vld = 1'b0;
            nxt_d.ofl      = '0;
            nxt_d.act      = 1'b0;
            nxt_d.abt_pend = 1'b0;
            nxt_d.abt_p    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign core_ack     = cur_q.ack;
    assign core_rdata   = cur_q.rdata;
    assign busy         = (cur_q.st != S_IDLE);
    assign tx_active    = cur_q.act;
    assign tx_committed = cur_q.cmt_p;
    assign tx_aborted   = cur_q.abt_p;
    assign mem_req      = cur_q.mreq;
    assign mem_we       = cur_q.mwe;
    assign mem_addr     = cur_q.maddr;
    assign mem_wdata    = cur_q.mwdata;

    // ---------------- assertions ----------------
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!mem_req && !core_ack && !tx_active && !busy));

    a_r12_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ack && busy));

    a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_committed && tx_aborted));

    a_r6_commit_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_committed) |-> (!tx_active && $past(busy)));

    a_r11_no_abort_in_commit: assert property (@(posedge clk) disable iff (!rst_n)
        committing |=> !tx_aborted);

    a_r2_flags_only_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (|cur_q.ofl) |-> cur_q.act);

    a_r13_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r6_table_drain_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_CMT_WR) |-> (mem_req && mem_we));

    a_r7_abort_closes_tx: assert property (@(posedge clk) disable iff (!rst_n)
        tx_aborted |-> !tx_active);
endmodule

// File: tb/txc_ovf_ctrl_bench.sv
module txc_ovf_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam int NLINES     = 8;
    localparam int NOVF       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0;
    logic [7:0]  core_addr = '0;
    logic [31:0] core_wdata = '0;
    logic        core_ack, busy, tx_active, tx_committed, tx_aborted;
    logic [31:0] core_rdata;
    logic        tx_begin = 1'b0, tx_commit = 1'b0, tx_intr = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [7:0]  snoop_addr = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    txc_ovf_ctrl u_txc_ovf_ctrl (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata), .busy(busy),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_intr(tx_intr),
        .tx_active(tx_active), .tx_committed(tx_committed), .tx_aborted(tx_aborted),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    // memory model: one-cycle acknowledge, image reloaded during reset
    logic [31:0] mem [256];
    int rd_cnt = 0, wr_cnt = 0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h1000 + 32'(i);
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // monitors
    int n_cmt = 0, n_abt = 0, busy_cyc = 0, ack_busy = 0, req_drop = 0;
    logic req_prev = 1'b0, ack_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_committed) n_cmt++;
            if (tx_aborted)   n_abt++;
            if (busy)         busy_cyc++;
            if (core_ack && busy) ack_busy++;
            if (req_prev && !ack_prev && !mem_req) req_drop++;
        end
        req_prev = mem_req;
        ack_prev = mem_ack;
    end

    int n_tests = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: got cycle %0d exp completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
        do @(negedge clk); while (!core_ack);
        rd = core_rdata;
        core_req = 1'b0;
    endtask

    task automatic begin_tx;
        @(negedge clk); tx_begin = 1'b1;
        @(negedge clk); tx_begin = 1'b0;
    endtask

    task automatic commit_tx;
        @(negedge clk); tx_commit = 1'b1;
        @(negedge clk); tx_commit = 1'b0;
        while (!tx_committed && !tx_aborted) @(negedge clk);
        wait_cyc(2);
    endtask

    task automatic snoop(input logic [7:0] a);
        @(negedge clk); snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk); snoop_valid = 1'b0;
        wait_cyc(4);
    endtask

    typedef struct packed {
        logic [1:0]  kind;   // 0 access, 1 begin, 2 commit
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t [0:9] VECS = '{
        '{2'd0, 1'b1, 8'h00, 32'h0000_00A1, 32'h0},
        '{2'd0, 1'b0, 8'h00, 32'h0,         32'h0000_00A1},
        '{2'd0, 1'b0, 8'h04, 32'h0,         32'h0000_1004},
        '{2'd0, 1'b0, 8'h08, 32'h0,         32'h0000_1008},
        '{2'd0, 1'b0, 8'h00, 32'h0,         32'h0000_00A1},
        '{2'd1, 1'b0, 8'h00, 32'h0,         32'h0},
        '{2'd0, 1'b1, 8'h01, 32'h0000_00B1, 32'h0},
        '{2'd0, 1'b0, 8'h01, 32'h0,         32'h0000_00B1},
        '{2'd2, 1'b0, 8'h00, 32'h0,         32'h0},
        '{2'd0, 1'b0, 8'h01, 32'h0,         32'h0000_00B1}
    };

    initial begin
        logic [31:0] rd;
        int a0, c0, r0, w0, b0;

        do_reset;
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 tx_active", 32'(tx_active), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 core_ack", 32'(core_ack), 0);

        // vector table: non-transactional write-back, then a small transaction
        for (int v = 0; v < 10; v++) begin
            if (v == 1) chk("R2 write held in cache", mem[0], 32'h1000);
            case (VECS[v].kind)
                2'd0: begin
                    access(VECS[v].we, VECS[v].addr, VECS[v].wdata, rd);
                    if (!VECS[v].we) chk("R2/R6 vector read", rd, VECS[v].exp);
                end
                2'd1: begin_tx;
                default: commit_tx;
            endcase
        end
        chk("R2 dirty eviction written home", mem[0], 32'h0000_00A1);

        // R3 clean before transactional touch, R9 interrupt abort
        do_reset;
        access(1'b1, 8'h02, 32'hC0, rd);
        begin_tx;
        access(1'b1, 8'h02, 32'hC1, rd);
        chk("R3 old dirty data written first", mem[2], 32'hC0);
        a0 = n_abt;
        @(negedge clk); tx_intr = 1'b1;
        @(negedge clk); tx_intr = 1'b0;
        wait_cyc(4);
        chk("R9 interrupt aborts", 32'(n_abt - a0), 1);
        chk("R9 tx closed", 32'(tx_active), 0);
        access(1'b0, 8'h02, 32'h0, rd);
        chk("R9 value restored", rd, 32'hC0);

        // R4 spill, R5 table lookup, R6 commit
        do_reset;
        begin_tx;
        w0 = wr_cnt;
        access(1'b1, 8'h00, 32'hD0, rd);
        access(1'b1, 8'h04, 32'hD1, rd);
        access(1'b1, 8'h08, 32'hD2, rd);
        chk("R4 no memory write on spill", 32'(wr_cnt - w0), 0);
        chk("R4 home untouched", mem[0], 32'h1000);
        r0 = rd_cnt;
        access(1'b0, 8'h00, 32'h0, rd);
        chk("R5 data from table", rd, 32'hD0);
        chk("R5 no memory read", 32'(rd_cnt - r0), 0);
        c0 = n_cmt; b0 = busy_cyc; a0 = n_abt;
        commit_tx;
        chk("R6 one commit pulse", 32'(n_cmt - c0), 1);
        chk("R6 busy spans walk", 32'(busy_cyc - b0 >= NLINES + NOVF), 1);
        chk("R6 spilled data home", mem[4], 32'hD1);
        chk("R6 tx closed", 32'(tx_active), 0);
        access(1'b0, 8'h00, 32'h0, rd);
        chk("R6 committed readable", rd, 32'hD0);
        access(1'b0, 8'h08, 32'h0, rd);
        chk("R6 committed readable 2", rd, 32'hD2);

        // R7 conflict on cached line
        do_reset;
        begin_tx;
        access(1'b1, 8'h10, 32'hE1, rd);
        a0 = n_abt;
        snoop(8'h10);
        chk("R7 cached conflict aborts", 32'(n_abt - a0), 1);
        access(1'b0, 8'h10, 32'h0, rd);
        chk("R7 cached restore", rd, 32'h1010);

        // R7 conflict on spilled line
        do_reset;
        begin_tx;
        access(1'b1, 8'h00, 32'hE2, rd);
        access(1'b1, 8'h04, 32'hE3, rd);
        access(1'b1, 8'h08, 32'hE4, rd);
        a0 = n_abt;
        snoop(8'h00);
        chk("R7 spilled conflict aborts", 32'(n_abt - a0), 1);
        access(1'b0, 8'h00, 32'h0, rd);
        chk("R7 spilled restore", rd, 32'h1000);
        access(1'b0, 8'h08, 32'h0, rd);
        chk("R7 written line dropped", rd, 32'h1008);

        // R8 unrelated snoop
        do_reset;
        begin_tx;
        access(1'b1, 8'h03, 32'h33, rd);
        a0 = n_abt; c0 = n_cmt;
        snoop(8'h07);
        chk("R8 no abort", 32'(n_abt - a0), 0);
        chk("R8 still active", 32'(tx_active), 1);
        commit_tx;
        chk("R8 commit ok", 32'(n_cmt - c0), 1);
        access(1'b0, 8'h03, 32'h0, rd);
        chk("R8 data kept", rd, 32'h33);

        // R10 table full
        do_reset;
        begin_tx;
        a0 = n_abt;
        for (int k = 0; k < 19; k++) access(1'b1, 8'(4 * k), 32'hF00 + 32'(k), rd);
        wait_cyc(2);
        chk("R10 full table aborts", 32'(n_abt - a0), 1);
        chk("R10 tx closed", 32'(tx_active), 0);
        access(1'b0, 8'h00, 32'h0, rd);
        chk("R10 spilled discarded", rd, 32'h1000);
        access(1'b0, 8'h48, 32'h0, rd);
        chk("R10 last access served", rd, 32'hF12);

        // R11 conflict during commit
        do_reset;
        begin_tx;
        access(1'b1, 8'h01, 32'h11, rd);
        a0 = n_abt; c0 = n_cmt;
        @(negedge clk); tx_commit = 1'b1;
        @(negedge clk); tx_commit = 1'b0; snoop_valid = 1'b1; snoop_addr = 8'h01;
        @(negedge clk); snoop_valid = 1'b0;
        while (!tx_committed && !tx_aborted) @(negedge clk);
        wait_cyc(4);
        chk("R11 commit wins", 32'(n_cmt - c0), 1);
        chk("R11 no abort", 32'(n_abt - a0), 0);
        access(1'b0, 8'h01, 32'h0, rd);
        chk("R11 data committed", rd, 32'h11);

        chk("R12 no ack while busy", 32'(ack_busy), 0);
        chk("R13 memory request held", 32'(req_drop), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule